// File: doc/BRIEF.md
# Byte-Lane Dual-Port RAM with Busy Arbitration

This block is a clocked model of a shared word memory that two independent agents reach through separate ports. Each port has an active-low enable, a read/write select, an active-low output enable, and one active-low select per byte lane. It also has its own address and its own write data bus. Tri-state pins are replaced by read data plus one valid flag per lane. An access is taken at a rising clock edge. Read results and busy flags appear one clock later.

When both ports reach the same word in the same cycle and at least one byte lane is common to both, the internal arbiter lets the left port through. It blocks the right port's write and raises the right port's busy flag. A cascade strap selects the mode. In master mode the arbiter drives the busy flags. In slave mode a master device supplies busy as inputs, one per port, and each input blocks that port's write in the same cycle. The default depth is 2^10 words. The full-size 16K x 16 arrangement uses `ADDR_W = 14`.

Top module: `byte_lane_dpram`

## Requirements
- R1: While a port's enable (`*_ce_ni`) is high, that port writes nothing, and its `*_rvalid_o` is all zero in the following cycle.
- R2: While both lane selects of a port are high, that port touches no lane, and its `*_rvalid_o` is zero in the following cycle, even with the enable low.
- R3: A write (enable low, `*_rw_i` low) stores only the lanes whose select is low. Lane select bit 1 guards data bits 15:8 and bit 0 guards bits 7:0.
- R4: A read (enable low, `*_rw_i` high, `*_oe_ni` low) sets, in the next cycle, the `*_rvalid_o` bits of the selected lanes (bit 1 upper, bit 0 lower) and returns their stored bytes. Unselected lanes show valid 0 and data 0.
- R5: With `*_oe_ni` high, neither lane of that port is marked valid in the next cycle.
- R6: In master mode (`master_i` = 1), a cycle in which both ports are enabled on the same address with at least one common lane raises `r_busy_o` in the next cycle. In that cycle the right write is dropped and the left write is stored.
- R7: In master mode, ports on different addresses, or on the same address with disjoint lanes, raise no busy flag, and both writes are stored.
- R8: `l_busy_o` stays low in master mode, because the left port wins every tie.
- R9: In slave mode (`master_i` = 0), both busy outputs stay low. A high `l_busy_i`/`r_busy_i` blocks that port's write in the same cycle but leaves its reads unaffected.
- R10: A read on one port of a word that the other port writes in the same cycle returns the old contents.
- R11: Reset clears both busy outputs and both valid vectors. Memory contents survive reset.
- R12: Each port addresses 2^ADDR_W distinct words. The lowest and highest addresses hold independent data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | Cascade strap: 1 = internal arbiter, 0 = busy taken from inputs |
| l_ce_ni | input | 1 | Left port enable, active low |
| l_rw_i | input | 1 | Left port direction: 1 = read, 0 = write |
| l_oe_ni | input | 1 | Left port output enable, active low |
| l_lane_ni | input | LANES | Left lane selects, active low (bit 1 upper byte) |
| l_addr_i | input | ADDR_W | Left word address |
| l_wdata_i | input | DATA_W | Left write data |
| l_busy_i | input | 1 | Left busy from a cascade master (slave mode) |
| l_rdata_o | output | DATA_W | Left read data, zero on unread lanes |
| l_rvalid_o | output | LANES | Left per-lane read valid |
| l_busy_o | output | 1 | Left busy flag (master mode) |
| r_ce_ni | input | 1 | Right port enable, active low |
| r_rw_i | input | 1 | Right port direction: 1 = read, 0 = write |
| r_oe_ni | input | 1 | Right port output enable, active low |
| r_lane_ni | input | LANES | Right lane selects, active low (bit 1 upper byte) |
| r_addr_i | input | ADDR_W | Right word address |
| r_wdata_i | input | DATA_W | Right write data |
| r_busy_i | input | 1 | Right busy from a cascade master (slave mode) |
| r_rdata_o | output | DATA_W | Right read data, zero on unread lanes |
| r_rvalid_o | output | LANES | Right per-lane read valid |
| r_busy_o | output | 1 | Right busy flag (master mode) |

## Verification
Each port gets full-word, upper-only and lower-only writes and reads. Reading back whole words shows which bytes a partial write changed. Reading single lanes separates the valid flags of the two lanes.

Same-address pairs are tried three ways: with overlapping lanes, with disjoint lanes, and as write against read. This tells a true clash apart from a harmless shared word, and it exposes the old-data read.

Slave-mode patterns raise each busy input during a write and during a read. The only visible effect should be the dropped write.

Accesses at address 0 and at the top address show that no address bit is lost.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic {
      MODE_SLAVE  = 1'b0,
      MODE_MASTER = 1'b1
   } cascade_mode_e;

endpackage

// File: rtl/dpr_port_decode.sv
// Control decode for one port: which lanes are touched, written or read.
module dpr_port_decode #(
   parameter int LANES = 2
) (
   input  logic             ce_ni,
   input  logic             rw_i,
   input  logic             oe_ni,
   input  logic [LANES-1:0] lane_ni,
   input  logic             block_i,
   output logic [LANES-1:0] lane_on_o,
   output logic [LANES-1:0] wr_en_o,
   output logic [LANES-1:0] rd_en_o
);

   // R1 R2: a disabled port or a port with no lane selected touches nothing
   assign lane_on_o = ce_ni ? '0 : ~lane_ni;

   // R3: write goes only to the selected lanes, unless arbitration blocks it
   assign wr_en_o = (!rw_i && !block_i) ? lane_on_o : '0;

   // R4 R5: read needs the output enable as well
   assign rd_en_o = (rw_i && !oe_ni) ? lane_on_o : '0;

endmodule

// File: rtl/dpr_arbiter.sv
// Same-address contention judge plus master/slave busy handling.
module dpr_arbiter #(
   parameter int ADDR_W = 10,
   parameter int LANES  = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  dpr_pkg::cascade_mode_e mode_i,
   input  logic [LANES-1:0]      l_on_i,
   input  logic [LANES-1:0]      r_on_i,
   input  logic [ADDR_W-1:0]     l_addr_i,
   input  logic [ADDR_W-1:0]     r_addr_i,
   input  logic                  l_busy_i,
   input  logic                  r_busy_i,
   output logic                  l_block_o,
   output logic                  r_block_o,
   output logic                  l_busy_o,
   output logic                  r_busy_o
);

   logic is_master;
   logic clash;
   logic l_busy_q, r_busy_q;

   assign is_master = (mode_i == dpr_pkg::MODE_MASTER);
   assign clash     = (l_addr_i == r_addr_i) && (|(l_on_i & r_on_i));

   // Left wins every tie in master mode; in slave mode the cascade inputs rule.
   assign l_block_o = is_master ? 1'b0  : l_busy_i;
   assign r_block_o = is_master ? clash : r_busy_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         l_busy_q <= 1'b0;
         r_busy_q <= 1'b0;
      end else begin
         l_busy_q <= 1'b0;
         r_busy_q <= is_master && clash;
      end
   end

   assign l_busy_o = l_busy_q;
   assign r_busy_o = r_busy_q;

   // R6
   clash_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == dpr_pkg::MODE_MASTER && l_addr_i == r_addr_i && (|(l_on_i & r_on_i)))
      |=> r_busy_o);

   // R7
   apart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (l_addr_i != r_addr_i || (l_on_i & r_on_i) == '0) |=> !r_busy_o);

   // R8
   left_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == dpr_pkg::MODE_MASTER) |=> !l_busy_o);

   // R9
   slave_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == dpr_pkg::MODE_SLAVE) |=> !(l_busy_o || r_busy_o));

endmodule

// File: rtl/dpr_lane_ram.sv
// One byte lane of storage with two write ports and two registered read ports.
module dpr_lane_ram #(
   parameter int ADDR_W = 10,
   parameter int WIDTH  = 8
) (
   input  logic              clk_i,
   input  logic              a_we_i,
   input  logic              a_re_i,
   input  logic [ADDR_W-1:0] a_addr_i,
   input  logic [WIDTH-1:0]  a_wdata_i,
   output logic [WIDTH-1:0]  a_rdata_o,
   input  logic              b_we_i,
   input  logic              b_re_i,
   input  logic [ADDR_W-1:0] b_addr_i,
   input  logic [WIDTH-1:0]  b_wdata_i,
   output logic [WIDTH-1:0]  b_rdata_o
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [WIDTH-1:0] mem [DEPTH];

   // R10: reads sample the array before this edge's writes land
   always_ff @(posedge clk_i) begin
      if (a_we_i) mem[a_addr_i] <= a_wdata_i;
      if (b_we_i) mem[b_addr_i] <= b_wdata_i;
      a_rdata_o <= a_re_i ? mem[a_addr_i] : '0;
      b_rdata_o <= b_re_i ? mem[b_addr_i] : '0;
   end

endmodule

// File: rtl/byte_lane_dpram.sv
// Two-port word memory with per-byte-lane control and same-address arbitration.
module byte_lane_dpram #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16,
   localparam int LANES = DATA_W / dpr_pkg::BYTE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              master_i,
   input  logic              l_ce_ni,
   input  logic              l_rw_i,
   input  logic              l_oe_ni,
   input  logic [LANES-1:0]  l_lane_ni,
   input  logic [ADDR_W-1:0] l_addr_i,
   input  logic [DATA_W-1:0] l_wdata_i,
   input  logic              l_busy_i,
   output logic [DATA_W-1:0] l_rdata_o,
   output logic [LANES-1:0]  l_rvalid_o,
   output logic              l_busy_o,
   input  logic              r_ce_ni,
   input  logic              r_rw_i,
   input  logic              r_oe_ni,
   input  logic [LANES-1:0]  r_lane_ni,
   input  logic [ADDR_W-1:0] r_addr_i,
   input  logic [DATA_W-1:0] r_wdata_i,
   input  logic              r_busy_i,
   output logic [DATA_W-1:0] r_rdata_o,
   output logic [LANES-1:0]  r_rvalid_o,
   output logic              r_busy_o
);

   localparam int BW = dpr_pkg::BYTE_W;

   if (DATA_W < BW || (DATA_W % BW) != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W out of supported range");
   end

   logic [LANES-1:0] l_on, r_on, l_wr, r_wr, l_rd, r_rd;
   logic             l_block, r_block;
   logic [LANES-1:0] l_rvalid_q, r_rvalid_q;

   dpr_port_decode #(.LANES(LANES)) u_l_dec (
      .ce_ni(l_ce_ni), .rw_i(l_rw_i), .oe_ni(l_oe_ni), .lane_ni(l_lane_ni),
      .block_i(l_block), .lane_on_o(l_on), .wr_en_o(l_wr), .rd_en_o(l_rd)
   );

   dpr_port_decode #(.LANES(LANES)) u_r_dec (
      .ce_ni(r_ce_ni), .rw_i(r_rw_i), .oe_ni(r_oe_ni), .lane_ni(r_lane_ni),
      .block_i(r_block), .lane_on_o(r_on), .wr_en_o(r_wr), .rd_en_o(r_rd)
   );

   dpr_arbiter #(.ADDR_W(ADDR_W), .LANES(LANES)) u_arb (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .mode_i(dpr_pkg::cascade_mode_e'(master_i)),
      .l_on_i(l_on), .r_on_i(r_on), .l_addr_i(l_addr_i), .r_addr_i(r_addr_i),
      .l_busy_i(l_busy_i), .r_busy_i(r_busy_i),
      .l_block_o(l_block), .r_block_o(r_block),
      .l_busy_o(l_busy_o), .r_busy_o(r_busy_o)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      dpr_lane_ram #(.ADDR_W(ADDR_W), .WIDTH(BW)) u_ram (
         .clk_i(clk_i),
         .a_we_i(l_wr[g]), .a_re_i(l_rd[g]), .a_addr_i(l_addr_i),
         .a_wdata_i(l_wdata_i[g*BW +: BW]), .a_rdata_o(l_rdata_o[g*BW +: BW]),
         .b_we_i(r_wr[g]), .b_re_i(r_rd[g]), .b_addr_i(r_addr_i),
         .b_wdata_i(r_wdata_i[g*BW +: BW]), .b_rdata_o(r_rdata_o[g*BW +: BW])
      );
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         l_rvalid_q <= '0;
         r_rvalid_q <= '0;
      end else begin
         l_rvalid_q <= l_rd;
         r_rvalid_q <= r_rd;
      end
   end

   assign l_rvalid_o = l_rvalid_q;
   assign r_rvalid_o = r_rvalid_q;

   // R1 R5
   l_noread_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (l_ce_ni || !l_rw_i || l_oe_ni) |=> (l_rvalid_o == '0));

   // R1 R5
   r_noread_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (r_ce_ni || !r_rw_i || r_oe_ni) |=> (r_rvalid_o == '0));

   // R2
   l_nolane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (l_lane_ni == '1) |=> (l_rvalid_o == '0));

   // R4
   r_lane_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!r_ce_ni && r_rw_i && !r_oe_ni) |=> (r_rvalid_o == ~$past(r_lane_ni)));

endmodule

// File: tb/byte_lane_dpram_test.sv
module byte_lane_dpram_test;

   localparam int CLK_P = 10;
   localparam int AW    = 10;

   typedef struct packed {
      logic        m;
      logic        lce, lrw, loe;
      logic [1:0]  llan;
      logic [9:0]  la;
      logic [15:0] lwd;
      logic        rce, rrw, roe;
      logic [1:0]  rlan;
      logic [9:0]  ra;
      logic [15:0] rwd;
      logic        bli, bri;
      logic [1:0]  elv;
      logic [15:0] eld;
      logic [1:0]  erv;
      logic [15:0] erd;
      logic        ebl, ebr;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VECS [NV] = '{
      // 0 R3 R7: full writes, different addresses
      '{1'b1, 1'b0,1'b0,1'b1,2'b00,10'd5,16'h1234, 1'b0,1'b0,1'b1,2'b00,10'd6,16'hABCD, 1'b0,1'b0, 2'b00,16'h0000,2'b00,16'h0000,1'b0,1'b0},
      // 1 R4: full reads
      '{1'b1, 1'b0,1'b1,1'b0,2'b00,10'd5,16'h0000, 1'b0,1'b1,1'b0,2'b00,10'd6,16'h0000, 1'b0,1'b0, 2'b11,16'h1234,2'b11,16'hABCD,1'b0,1'b0},
      // 2 R3: left upper-only write
      '{1'b1, 1'b0,1'b0,1'b1,2'b01,10'd5,16'h55AA, 1'b1,1'b1,1'b1,2'b11,10'd0,16'h0000, 1'b0,1'b0, 2'b00,16'h0000,2'b00,16'h0000,1'b0,1'b0},
      // 3 R3: left reads merged word, right lower-only write
      '{1'b1, 1'b0,1'b1,1'b0,2'b00,10'd5,16'h0000, 1'b0,1'b0,1'b1,2'b10,10'd6,16'h0011, 1'b0,1'b0, 2'b11,16'h5534,2'b00,16'h0000,1'b0,1'b0},
      // 4 R4: single-lane reads
      '{1'b1, 1'b0,1'b1,1'b0,2'b01,10'd5,16'h0000, 1'b0,1'b1,1'b0,2'b10,10'd6,16'h0000, 1'b0,1'b0, 2'b10,16'h5500,2'b01,16'h0011,1'b0,1'b0},
      // 5 R5 left oe high, R2 right no lanes
      '{1'b1, 1'b0,1'b1,1'b1,2'b00,10'd5,16'h0000, 1'b0,1'b1,1'b0,2'b11,10'd6,16'h0000, 1'b0,1'b0, 2'b00,16'h0000,2'b00,16'h0000,1'b0,1'b0},
      // 6 R1: deselected write and read
      '{1'b1, 1'b1,1'b0,1'b1,2'b00,10'd5,16'hFFFF, 1'b1,1'b1,1'b0,2'b00,10'd6,16'h0000, 1'b0,1'b0, 2'b00,16'h0000,2'b00,16'h0000,1'b0,1'b0},
      // 7 R1: contents unchanged
      '{1'b1, 1'b0,1'b1,1'b0,2'b00,10'd5,16'h0000, 1'b0,1'b1,1'b0,2'b00,10'd6,16'h0000, 1'b0,1'b0, 2'b11,16'h5534,2'b11,16'hAB11,1'b0,1'b0},
      // 8 R6: write clash
      '{1'b1, 1'b0,1'b0,1'b1,2'b00,10'd7,16'h1111, 1'b0,1'b0,1'b1,2'b00,10'd7,16'h2222, 1'b0,1'b0, 2'b00,16'h0000,2'b00,16'h0000,1'b0,1'b1},
      // 9 R6: left value kept
      '{1'b1, 1'b0,1'b1,1'b0,2'b00,10'd7,16'h0000, 1'b1,1'b1,1'b1,2'b11,10'd0,16'h0000, 1'b0,1'b0, 2'b11,16'h1111,2'b00,16'h0000,1'b0,1'b0},
      // 10 R7: same word, disjoint lanes
      '{1'b1, 1'b0,1'b0,1'b1,2'b01,10'd8,16'hAA00, 1'b0,1'b0,1'b1,2'b10,10'd8,16'h00BB, 1'b0,1'b0, 2'b00,16'h0000,2'b00,16'h0000,1'b0,1'b0},
      // 11 R7: both lanes stored
      '{1'b1, 1'b0,1'b1,1'b0,2'b00,10'd8,16'h0000, 1'b1,1'b1,1'b1,2'b11,10'd0,16'h0000, 1'b0,1'b0, 2'b11,16'hAABB,2'b00,16'h0000,1'b0,1'b0},
      // 12 R10: right reads old data while left writes
      '{1'b1, 1'b0,1'b0,1'b1,2'b00,10'd8,16'h1234, 1'b0,1'b1,1'b0,2'b00,10'd8,16'h0000, 1'b0,1'b0, 2'b00,16'h0000,2'b11,16'hAABB,1'b0,1'b1},
      // 13 R6 R8: read clash, both see new data
      '{1'b1, 1'b0,1'b1,1'b0,2'b00,10'd8,16'h0000, 1'b0,1'b1,1'b0,2'b00,10'd8,16'h0000, 1'b0,1'b0, 2'b11,16'h1234,2'b11,16'h1234,1'b0,1'b1},
      // 14 R7: set up words 9 and 10
      '{1'b1, 1'b0,1'b0,1'b1,2'b00,10'd9,16'h0F0F, 1'b0,1'b0,1'b1,2'b00,10'd10,16'h7777, 1'b0,1'b0, 2'b00,16'h0000,2'b00,16'h0000,1'b0,1'b0},
      // 15 R9: slave, both writes blocked by busy inputs
      '{1'b0, 1'b0,1'b0,1'b1,2'b00,10'd9,16'h8888, 1'b0,1'b0,1'b1,2'b00,10'd10,16'hF0F0, 1'b1,1'b1, 2'b00,16'h0000,2'b00,16'h0000,1'b0,1'b0},
      // 16 R9: reads pass with busy inputs high
      '{1'b0, 1'b0,1'b1,1'b0,2'b00,10'd10,16'h0000, 1'b0,1'b1,1'b0,2'b00,10'd9,16'h0000, 1'b1,1'b1, 2'b11,16'h7777,2'b11,16'h0F0F,1'b0,1'b0},
      // 17 R9: slave same-address reads raise no busy
      '{1'b0, 1'b0,1'b1,1'b0,2'b00,10'd9,16'h0000, 1'b0,1'b1,1'b0,2'b00,10'd9,16'h0000, 1'b0,1'b0, 2'b11,16'h0F0F,2'b11,16'h0F0F,1'b0,1'b0},
      // 18 R9: slave write with busy low
      '{1'b0, 1'b0,1'b0,1'b1,2'b00,10'd9,16'h4444, 1'b1,1'b1,1'b1,2'b11,10'd0,16'h0000, 1'b0,1'b0, 2'b00,16'h0000,2'b00,16'h0000,1'b0,1'b0},
      // 19 R9: stored value visible
      '{1'b0, 1'b0,1'b1,1'b0,2'b00,10'd9,16'h0000, 1'b1,1'b1,1'b1,2'b11,10'd0,16'h0000, 1'b0,1'b1, 2'b11,16'h4444,2'b00,16'h0000,1'b0,1'b0},
      // 20 R12: extreme addresses written
      '{1'b1, 1'b0,1'b0,1'b1,2'b00,10'd0,16'h0001, 1'b0,1'b0,1'b1,2'b00,10'd1023,16'h8000, 1'b0,1'b0, 2'b00,16'h0000,2'b00,16'h0000,1'b0,1'b0},
      // 21 R12: extreme addresses cross-read
      '{1'b1, 1'b0,1'b1,1'b0,2'b00,10'd1023,16'h0000, 1'b0,1'b1,1'b0,2'b00,10'd0,16'h0000, 1'b0,1'b0, 2'b11,16'h8000,2'b11,16'h0001,1'b0,1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        master;
   logic        l_ce_n, l_rw, l_oe_n, l_bi, r_ce_n, r_rw, r_oe_n, r_bi;
   logic [1:0]  l_lane_n, r_lane_n, l_rv, r_rv;
   logic [AW-1:0] l_addr, r_addr;
   logic [15:0] l_wd, r_wd, l_rd, r_rd;
   logic        l_bo, r_bo;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   byte_lane_dpram #(.ADDR_W(AW), .DATA_W(16)) uut (
      .clk_i(clk), .rst_ni(rst_n), .master_i(master),
      .l_ce_ni(l_ce_n), .l_rw_i(l_rw), .l_oe_ni(l_oe_n), .l_lane_ni(l_lane_n),
      .l_addr_i(l_addr), .l_wdata_i(l_wd), .l_busy_i(l_bi),
      .l_rdata_o(l_rd), .l_rvalid_o(l_rv), .l_busy_o(l_bo),
      .r_ce_ni(r_ce_n), .r_rw_i(r_rw), .r_oe_ni(r_oe_n), .r_lane_ni(r_lane_n),
      .r_addr_i(r_addr), .r_wdata_i(r_wd), .r_busy_i(r_bi),
      .r_rdata_o(r_rd), .r_rvalid_o(r_rv), .r_busy_o(r_bo)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      master = v.m;
      l_ce_n = v.lce; l_rw = v.lrw; l_oe_n = v.loe; l_lane_n = v.llan;
      l_addr = v.la;  l_wd = v.lwd;
      r_ce_n = v.rce; r_rw = v.rrw; r_oe_n = v.roe; r_lane_n = v.rlan;
      r_addr = v.ra;  r_wd = v.rwd;
      l_bi = v.bli;   r_bi = v.bri;
   endtask

   task automatic set_idle();
      l_ce_n = 1'b1; l_rw = 1'b1; l_oe_n = 1'b1; l_lane_n = 2'b11; l_addr = '0; l_wd = '0;
      r_ce_n = 1'b1; r_rw = 1'b1; r_oe_n = 1'b1; r_lane_n = 2'b11; r_addr = '0; r_wd = '0;
      l_bi = 1'b0; r_bi = 1'b0; master = 1'b1;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      set_idle();
      repeat (3) @(negedge clk);
      // R11: state while in reset
      chk("R11", "busy flags in reset", {30'd0, l_bo, r_bo}, 32'd0);
      chk("R11", "valid in reset", {28'd0, l_rv, r_rv}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         @(posedge clk);
         @(negedge clk);
         chk("R1-vector", $sformatf("left read v%0d", i),
             {14'd0, l_rv, l_rd}, {14'd0, VECS[i].elv, VECS[i].eld});
         chk("R4-vector", $sformatf("right read v%0d", i),
             {14'd0, r_rv, r_rd}, {14'd0, VECS[i].erv, VECS[i].erd});
         chk("R6-vector", $sformatf("busy v%0d", i),
             {30'd0, l_bo, r_bo}, {30'd0, VECS[i].ebl, VECS[i].ebr});
      end

      // R11: reset in the middle of a read clash clears busy and valid
      master = 1'b1;
      l_ce_n = 1'b0; l_rw = 1'b1; l_oe_n = 1'b0; l_lane_n = 2'b00; l_addr = 10'd9;
      r_ce_n = 1'b0; r_rw = 1'b1; r_oe_n = 1'b0; r_lane_n = 2'b00; r_addr = 10'd9;
      @(posedge clk);
      @(negedge clk);
      chk("R6", "busy before reset", {31'd0, r_bo}, 32'd1);
      rst_n = 1'b0;
      #1;
      chk("R11", "busy cleared by reset", {30'd0, l_bo, r_bo}, 32'd0);
      chk("R11", "valid cleared by reset", {28'd0, l_rv, r_rv}, 32'd0);
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      r_ce_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      // R11: memory survives reset
      chk("R11", "memory kept over reset", {14'd0, l_rv, l_rd}, {14'd0, 2'b11, 16'h4444});
      chk("R7", "single port raises no busy", {30'd0, l_bo, r_bo}, 32'd0);

      // R2: enable low but no lane selected on a write leaves the word alone
      l_ce_n = 1'b0; l_rw = 1'b0; l_lane_n = 2'b11; l_addr = 10'd9; l_wd = 16'hDEAD;
      @(posedge clk);
      @(negedge clk);
      l_rw = 1'b1; l_oe_n = 1'b0; l_lane_n = 2'b00;
      @(posedge clk);
      @(negedge clk);
      chk("R2", "no-lane write ignored", {14'd0, l_rv, l_rd}, {14'd0, 2'b11, 16'h4444});

      set_idle();
      done = 1'b1;
      summary();
      $finish;
   end

endmodule